// File: doc/BRIEF.md
# Periodic Tick Event Count Monitor

This block is a synchronous observer placed beside a sensor controller. It checks one safety response. A periodic tick opens an observation window. If a set number of sensor events arrive in that window (four by default) and no reset event has voided it, the controller must have raised its error event at some point in the window. If it has not, the monitor raises a violation pulse. The monitor only watches. It never produces the error itself.

Every input is a one-cycle pulse, sampled once per clock. Several pulses can land on the same cycle, and each such case is settled by a fixed rule. A sensor pulse on the opening tick does not count. A reset pulse on the opening tick does not void the window. When the closing sensor pulse coincides with the next tick, it still completes the old window, and the new window opens on that same cycle. A reset pulse on the completing cycle voids the window. The violation pulse comes out on the cycle of the completing sensor event. A sticky flag records that any violation has occurred since the last synchronous reset.

Top module: `tick_event_monitor`

## Requirements
- R1: A synchronous reset clears the sensor count, the void bit, the error-seen bit and the sticky flag, and leaves no window open. The violation output stays low during reset. Sensor events after reset and before the first tick never cause a violation.
- R2: A tick opens a window. A sensor event on the same cycle as the opening tick is not counted.
- R3: The violation output is high, combinationally, on the cycle of the fourth counted sensor event, but only when no error event and no voiding reset event occurred in the window. It is never high on a cycle without a sensor event.
- R4: An error event on any cycle from the opening tick through the fourth counted sensor event, both included, suppresses the violation.
- R5: A reset event on the opening tick does not void the window. A reset event on any later cycle of the window, up to and including the cycle of the fourth counted sensor event, voids it, and no violation follows.
- R6: Each tick restarts the window and clears the count, the void bit and the error-seen bit. A fourth sensor event on the same cycle as the next tick still completes the previous window.
- R7: Sensor events after the fourth in a window are ignored, so each window raises the violation at most once.
- R8: The sticky flag goes high on the clock edge that ends a violation cycle. It stays high until a synchronous reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Periodic tick pulse that opens a window |
| sense_i | input | 1 | Sensor event pulse |
| rst_evt_i | input | 1 | Controller reset event pulse |
| err_evt_i | input | 1 | Controller error response pulse |
| viol_o | output | 1 | Violation pulse on the completing sensor cycle |
| viol_sticky_o | output | 1 | Set after any violation, cleared by reset |

## Verification
The bench concentrates on same-cycle coincidences, because a plausible design tends to get these wrong.

- Tick with sensor: a design that counted the sensor pulse on the tick would fire one event early.
- Reset event with the opening tick: a design that let this reset void the window would miss a real violation.
- Fourth sensor with the next tick: a design that cleared the count first would lose the violation at the window boundary.
- Fourth sensor with a reset or error event: a design that registered these pulses before using them would report a false violation.

Tests of window restarts confirm the following. A stale error, a stale reset or a partial count does not leak into the next window. Sensor events before the first tick, and after the fourth event of a window, raise nothing.

// File: rtl/tem_pkg.sv
package tem_pkg;

    // Window state: closed until the first tick, then open for good.
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    typedef struct packed {
        win_state_e state;
        logic       void_f;
        logic       err_seen;
    } win_regs_t;

endpackage

// File: rtl/tem_counter.sv
module tem_counter #(
    parameter int unsigned TARGET = 4,
    parameter int unsigned CNT_W  = $clog2(TARGET + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic inc_i,
    output logic reach_o,
    output logic full_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TARGET - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             full;
    } cnt_regs_t;

    cnt_regs_t r_q, r_d;

    // reach_o is taken from the state before clear_i acts, so an event on a
    // restart cycle still closes the old window.
    always_comb begin
        r_d     = r_q;
        reach_o = inc_i && !r_q.full && (r_q.cnt == LAST);
        if (rst || clear_i) begin
            r_d.cnt  = '0;
            r_d.full = 1'b0;
        end else if (inc_i && !r_q.full) begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
            if (r_q.cnt == LAST) begin
                r_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign full_o = r_q.full;

endmodule

// File: rtl/tem_window.sv
module tem_window
    import tem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic rst_evt_i,
    input  logic err_evt_i,
    output logic open_o,
    output logic void_o,
    output logic err_seen_o
);

    win_regs_t w_q, w_d;

    always_comb begin
        w_d = w_q;
        if (rst) begin
            w_d.state    = WIN_IDLE;
            w_d.void_f   = 1'b0;
            w_d.err_seen = 1'b0;
        end else if (tick_i) begin
            // A reset event on the opening tick is ignored. An error on it counts.
            w_d.state    = WIN_OPEN;
            w_d.void_f   = 1'b0;
            w_d.err_seen = err_evt_i;
        end else if (w_q.state == WIN_OPEN) begin
            w_d.void_f   = w_q.void_f | rst_evt_i;
            w_d.err_seen = w_q.err_seen | err_evt_i;
        end
    end

    always_ff @(posedge clk) begin
        w_q <= w_d;
    end

    assign open_o     = (w_q.state == WIN_OPEN);
    assign void_o     = w_q.void_f;
    assign err_seen_o = w_q.err_seen;

endmodule

// File: rtl/tick_event_monitor.sv
module tick_event_monitor #(
    parameter int unsigned EVENT_TARGET = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic sense_i,
    input  logic rst_evt_i,
    input  logic err_evt_i,
    output logic viol_o,
    output logic viol_sticky_o
);

    localparam int unsigned CNT_W = $clog2(EVENT_TARGET + 1);

    logic win_open, win_void, win_err;
    logic cnt_reach, cnt_full;
    logic sense_inc;
    logic viol_now;

    typedef struct packed {
        logic sticky;
    } top_regs_t;

    top_regs_t t_q, t_d;

    assign sense_inc = sense_i && win_open;

    tem_window u_window (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .rst_evt_i  (rst_evt_i),
        .err_evt_i  (err_evt_i),
        .open_o     (win_open),
        .void_o     (win_void),
        .err_seen_o (win_err)
    );

    tem_counter #(
        .TARGET (EVENT_TARGET),
        .CNT_W  (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .clear_i (tick_i),
        .inc_i   (sense_inc),
        .reach_o (cnt_reach),
        .full_o  (cnt_full)
    );

    // Completing cycle: this cycle's reset and error pulses also decide.
    always_comb begin
        viol_now = !rst && cnt_reach && !win_void && !win_err
                   && !rst_evt_i && !err_evt_i;
        t_d = t_q;
        if (rst) begin
            t_d.sticky = 1'b0;
        end else if (viol_now) begin
            t_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign viol_o        = viol_now;
    assign viol_sticky_o = t_q.sticky;

    logic unused_full;
    assign unused_full = cnt_full;

endmodule

// File: rtl/tick_event_monitor_chk.sv
module tick_event_monitor_chk (
    input logic clk,
    input logic rst,
    input logic tick_i,
    input logic sense_i,
    input logic rst_evt_i,
    input logic err_evt_i,
    input logic viol_o,
    input logic viol_sticky_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !viol_sticky_o); // R1
    AST_QUIET_IN_RESET: assert property (@(posedge clk) rst |-> !viol_o); // R1
    AST_NEEDS_SENSE: assert property (@(posedge clk) disable iff (rst) !sense_i |-> !viol_o); // R3
    AST_ERR_SUPPRESS: assert property (@(posedge clk) disable iff (rst) err_evt_i |-> !viol_o); // R4
    AST_RSTEVT_SUPPRESS: assert property (@(posedge clk) disable iff (rst) rst_evt_i |-> !viol_o); // R5
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) viol_o |=> !viol_o); // R7
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst) viol_o |=> viol_sticky_o); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst) viol_sticky_o |=> viol_sticky_o); // R8
    AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(viol_sticky_o) |-> $past(viol_o)); // R8

    logic unused_tick;
    assign unused_tick = tick_i;

endmodule

bind tick_event_monitor tick_event_monitor_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .sense_i       (sense_i),
    .rst_evt_i     (rst_evt_i),
    .err_evt_i     (err_evt_i),
    .viol_o        (viol_o),
    .viol_sticky_o (viol_sticky_o)
);

// File: tb/tick_event_monitor_test.sv
module tick_event_monitor_test;

    logic clk = 1'b0;
    logic rst, tick, sense, revt, eevt;
    logic viol, sticky;

    int checks = 0;
    int errors = 0;
    logic exp_sticky = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tick_event_monitor #(.EVENT_TARGET(4)) uut (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick),
        .sense_i       (sense),
        .rst_evt_i     (revt),
        .err_evt_i     (eevt),
        .viol_o        (viol),
        .viol_sticky_o (sticky)
    );

    // Bits: {rst, tick, sense, reset_evt, err_evt, expected_violation}
    localparam int NV = 47;
    localparam logic [5:0] VEC [NV] = '{
        // R1: sensors with no window open
        6'b001000, 6'b001000, 6'b001000, 6'b001000,
        // R2 R3 R7: tick+sense not counted, fire on fourth, fifth ignored
        6'b011000, 6'b001000, 6'b001000, 6'b001000, 6'b001001, 6'b001000,
        // R1 R8: reset clears sticky
        6'b100000, 6'b000000,
        // R4: error on the opening tick
        6'b010010, 6'b001000, 6'b001000, 6'b001000, 6'b001000,
        // R5: reset event on the opening tick does not void
        6'b010100, 6'b001000, 6'b001000, 6'b001000, 6'b001001,
        // R5: reset event mid-window voids
        6'b010000, 6'b001000, 6'b000100, 6'b001000, 6'b001000, 6'b001000,
        // R5: reset event with the fourth sensor voids
        6'b010000, 6'b001000, 6'b001000, 6'b001000, 6'b001100,
        // R4: error with the fourth sensor
        6'b010000, 6'b001000, 6'b001000, 6'b001000, 6'b001010,
        // R6: fourth sensor on the next tick completes, new window counts afresh
        6'b010000, 6'b001000, 6'b001000, 6'b001000, 6'b011001,
        6'b001000, 6'b001000, 6'b001000, 6'b001001
    };

    task automatic step(input logic [5:0] v, input string tag);
        @(negedge clk);
        {rst, tick, sense, revt, eevt} = v[5:1];
        #2;
        checks++;
        if (viol !== v[0]) begin
            errors++;
            $display("FAIL %s viol actual=%b expected=%b", tag, viol, v[0]);
        end
        checks++;
        if (sticky !== exp_sticky) begin
            errors++;
            $display("FAIL %s/R8 sticky actual=%b expected=%b", tag, sticky, exp_sticky);
        end
        @(posedge clk);
        exp_sticky = v[5] ? 1'b0 : (exp_sticky | v[0]);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        {rst, tick, sense, revt, eevt} = 5'b10000;
        @(posedge clk);
        @(posedge clk);
        exp_sticky = 1'b0;
        step(6'b100000, "R1 reset");
        step(6'b000000, "R1 idle");
        for (int i = 0; i < NV; i++) begin
            step(VEC[i], $sformatf("vector %0d", i));
        end
        // R6: tick restarts a partial count
        step(6'b010000, "R6");
        step(6'b001000, "R6"); step(6'b001000, "R6"); step(6'b001000, "R6");
        step(6'b010000, "R6");
        step(6'b001000, "R6"); step(6'b001000, "R6"); step(6'b001000, "R6");
        step(6'b001001, "R6 restart");
        // R6: error seen in the previous window is dropped
        step(6'b010000, "R6"); step(6'b000010, "R6"); step(6'b010000, "R6");
        step(6'b001000, "R6"); step(6'b001000, "R6"); step(6'b001000, "R6");
        step(6'b001001, "R6 err cleared");
        // R6: void bit is dropped by the next tick
        step(6'b010000, "R6"); step(6'b000100, "R6"); step(6'b010000, "R6");
        step(6'b001000, "R6"); step(6'b001000, "R6"); step(6'b001000, "R6");
        step(6'b001001, "R6 void cleared");
        // R4: error on a completing tick covers both windows
        step(6'b010000, "R4"); step(6'b001000, "R4"); step(6'b001000, "R4");
        step(6'b001000, "R4"); step(6'b011010, "R4 boundary");
        step(6'b001000, "R4"); step(6'b001000, "R4"); step(6'b001000, "R4");
        step(6'b001000, "R4 carried");
        // R4: error on a gap cycle mid-window
        step(6'b010000, "R4"); step(6'b000010, "R4"); step(6'b000000, "R4");
        step(6'b001000, "R4"); step(6'b001000, "R4"); step(6'b001000, "R4");
        step(6'b001000, "R4 mid");
        // R1: reset mid-window closes it
        step(6'b010000, "R1"); step(6'b001000, "R1"); step(6'b001000, "R1");
        step(6'b100000, "R1 reset");
        step(6'b001000, "R1"); step(6'b001000, "R1"); step(6'b001000, "R1");
        step(6'b001000, "R1 no window");
        // R1: violation output is held low during reset
        step(6'b010000, "R1"); step(6'b001000, "R1"); step(6'b001000, "R1");
        step(6'b001000, "R1"); step(6'b101000, "R1 quiet");
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule